// File: doc/BRIEF.md
# Add/Subtract Flag Unit with Branch Condition Check

This block performs one integer addition or subtraction per accepted transfer and reports four status bits about the result: negative (N), zero (Z), carry (C) and signed overflow (V). Subtraction has no datapath of its own. The second operand goes through the same adder after two's-complement negation: every bit is inverted and the carry-in is forced to one. The four bits are kept in a status register. That register is rewritten only when the caller asks for it.

A separate combinational checker reads the stored status bits and a 4-bit condition code, and reports whether a conditional branch would be taken. The signed comparisons are derived from the relations between N, V and Z, so there is no magnitude comparator.

Operands enter through a valid/ready port, and results leave through another. An operation is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty, or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result is held and no new operation is accepted. The condition code and `cond_true` are plain control pins with no handshake.

Top module: `flagcalc_core`

## Requirements
- R1: With `op_sub` = 0, an accepted operation produces `out_result` = `op_a` + `op_b` modulo 2^W. The result appears with `out_valid` = 1 from the clock edge that accepts it.
- R2: With `op_sub` = 1, an accepted operation produces `out_result` = `op_a` + (bitwise NOT `op_b`) + 1 modulo 2^W, which equals `op_a` − `op_b`.
- R3: After an accepted operation with `set_flags` = 1, `flag_n` equals bit W−1 of the result, and `flag_z` is 1 exactly when the result is all zeros.
- R4: `flag_c` is the carry out of the adder. For addition it is 1 when `op_a` + `op_b` ≥ 2^W. For subtraction it is 1 when `op_a` ≥ `op_b` as unsigned values, meaning no borrow.
- R5: `flag_v` is 1 when both adder inputs (`op_a`, and either `op_b` or its inverse) have the same sign bit and the result's sign bit differs from it. This holds exactly when the signed result falls outside the range of W-bit two's complement.
- R6: The status register changes only on an accepted operation with `set_flags` = 1. Otherwise it keeps its value, even when a result is produced. Reset clears all four bits to 0.
- R7: Condition code 4'b0000 is true when Z = 1. Condition code 4'b0001 is true when Z = 0.
- R8: Condition code 4'b1010 is true when N = V. Condition code 4'b1011 is true when N ≠ V.
- R9: Condition code 4'b1100 is true when Z = 0 and N = V. Condition code 4'b1101 is true exactly when 4'b1100 would be false.
- R10: Condition code 4'b1110 is always true. Every other code evaluates false.
- R11: `in_ready` = NOT `out_valid` OR `out_ready`. While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays 1 and `out_result` does not change.
- R12: After reset, `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and control bits are offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| op_a | input | W | First operand (minuend) |
| op_b | input | W | Second operand (subtrahend when subtracting) |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| set_flags | input | 1 | Write the status register with this operation's flags |
| out_valid | output | 1 | `out_result` holds an unread result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | W | Sum or difference |
| flag_n | output | 1 | Stored negative bit |
| flag_z | output | 1 | Stored zero bit |
| flag_c | output | 1 | Stored carry bit |
| flag_v | output | 1 | Stored overflow bit |
| cond_code | input | 4 | Branch condition selector |
| cond_true | output | 1 | Selected condition holds on the stored flags |

## Verification
The assertions assume a few things about the inputs:
- `rst_n` is low for at least one rising edge.
- Operands and control bits are at known values whenever `in_valid` is high.
- `cond_code` is never X.

The bench meets these by driving every input only at falling edges, from a defined value in reset onward. It offers operations only with all fields set, and sweeps `cond_code` over all sixteen codes after each flag-setting operation. Back-pressure is exercised by holding `out_ready` low while `in_valid` stays high with different operands, so the hold rule and the status-register hold rule are both under stress at once.

// File: rtl/flagcalc_pkg.sv
package flagcalc_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [3:0] {
    COND_EQ = 4'b0000,
    COND_NE = 4'b0001,
    COND_GE = 4'b1010,
    COND_LT = 4'b1011,
    COND_GT = 4'b1100,
    COND_LE = 4'b1101,
    COND_AL = 4'b1110
  } cond_e;

endpackage

// File: rtl/flagcalc_addsub.sv
module flagcalc_addsub
  import flagcalc_pkg::*;
#(
  parameter int W = 16,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output flags_t       flags
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic         carry_out;

  // subtraction: invert the subtrahend and inject one at the carry-in
  assign b_eff = sub ? ~b : b;

  generate
    if (RIPPLE) begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = sub;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
        assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
      end
      assign carry_out = cy[W];
    end else begin : g_behav
      logic [W:0] wide;
      assign wide      = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
      assign sum       = wide[W-1:0];
      assign carry_out = wide[W];
    end
  endgenerate

  always_comb begin
    flags.n = sum[MSB];
    flags.z = (sum == '0);
    flags.c = carry_out;
    flags.v = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end

endmodule

// File: rtl/flagcalc_cond.sv
module flagcalc_cond
  import flagcalc_pkg::*;
(
  input  logic [3:0] code,
  input  logic       n,
  input  logic       z,
  input  logic       v,
  output logic       taken
);
  logic ge;
  logic gt;

  assign ge = (n == v);
  assign gt = !z && ge;

  always_comb begin
    case (code)
      COND_EQ: taken = z;
      COND_NE: taken = !z;
      COND_GE: taken = ge;
      COND_LT: taken = !ge;
      COND_GT: taken = gt;
      COND_LE: taken = !gt;
      COND_AL: taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/flagcalc_core.sv
module flagcalc_core
  import flagcalc_pkg::*;
#(
  parameter int W = 16,
  parameter bit RIPPLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         op_sub,
  input  logic         set_flags,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  input  logic [3:0]   cond_code,
  output logic         cond_true
);
  localparam int MSB = W - 1;

  logic [W-1:0] sum;
  flags_t       next_flags;
  flags_t       stat_q;
  logic         accept;

  flagcalc_addsub #(.W(W), .RIPPLE(RIPPLE)) u_addsub (
    .a     (op_a),
    .b     (op_b),
    .sub   (op_sub),
    .sum   (sum),
    .flags (next_flags)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  // output slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= sum;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // status register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (accept && set_flags) stat_q <= next_flags;
  end

  assign flag_n = stat_q.n;
  assign flag_z = stat_q.z;
  assign flag_c = stat_q.c;
  assign flag_v = stat_q.v;

  flagcalc_cond u_cond (
    .code  (cond_code),
    .n     (stat_q.n),
    .z     (stat_q.z),
    .v     (stat_q.v),
    .taken (cond_true)
  );

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && set_flags) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  assert_nz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && set_flags) |=> (flag_z == (out_result == '0)) && (flag_n == out_result[MSB]));

  assert_sub_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && set_flags && op_sub) |=> (flag_c == ($past(op_a) >= $past(op_b))));

  assert_eq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == 4'b0000) |-> (cond_true == flag_z));

  assert_always_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == 4'b1110) |-> cond_true);

endmodule

// File: tb/flagcalc_core_test.sv
module flagcalc_core_test;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic op_sub = 1'b0;
  logic set_flags = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic flag_n, flag_z, flag_c, flag_v;
  logic [3:0] cond_code = 4'b0000;
  logic cond_true;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expected status bits {n,z,c,v}
  logic [3:0] exp_f = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  flagcalc_core #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .op_sub(op_sub), .set_flags(set_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .cond_code(cond_code), .cond_true(cond_true)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_res(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    return s ? W'(a - b) : W'(a + b);
  endfunction

  function automatic logic [3:0] model_flags(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    logic [W-1:0] r;
    longint sa, sb, ideal;
    logic c, v;
    r = model_res(a, b, s);
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ideal = s ? sa - sb : sa + sb;
    v = (ideal > 32767) || (ideal < -32768);
    c = s ? (a >= b) : ((32'(a) + 32'(b)) >= 32'h10000);
    return {r[W-1], (r == '0), c, v};
  endfunction

  function automatic logic model_cond(input logic [3:0] code, input logic [3:0] f);
    logic n, z, v;
    n = f[3]; z = f[1+1]; v = f[0];
    case (code)
      4'b0000: return z;
      4'b0001: return !z;
      4'b1010: return n == v;
      4'b1011: return n != v;
      4'b1100: return !z && (n == v);
      4'b1101: return !(!z && (n == v));
      4'b1110: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cond_tag(input logic [3:0] code);
    case (code)
      4'b0000, 4'b0001: return "R7";
      4'b1010, 4'b1011: return "R8";
      4'b1100, 4'b1101: return "R9";
      default:          return "R10";
    endcase
  endfunction

  task automatic check_flags(input string tag);
    check(tag, {flag_n, flag_z, flag_c, flag_v}, exp_f);
  endtask

  // one operation through an open output: drive at negedge, check at next negedge
  task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                       input logic sf, input string tag);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = s; set_flags = sf;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, out_valid, 1);
    check({tag, " result"}, out_result, model_res(a, b, s));
    if (sf) exp_f = model_flags(a, b, s);
    check_flags({tag, " flags"});
  endtask

  task automatic sweep_conds();
    for (int k = 0; k < 16; k++) begin
      cond_code = 4'(k);
      #1;
      check({cond_tag(4'(k)), " cond"}, cond_true, model_cond(4'(k), exp_f));
    end
  endtask

  task automatic t_reset();
    // R12 reset state, R6 cleared flags
    check("R12 out_valid", out_valid, 0);
    check("R12 in_ready", in_ready, 1);
    check_flags("R6 reset flags");
    sweep_conds();
  endtask

  task automatic t_add();
    do_op(16'h0001, 16'h0002, 1'b0, 1'b1, "R1 small");      sweep_conds();
    do_op(16'h7FFF, 16'h0001, 1'b0, 1'b1, "R5 add ovf");    sweep_conds();
    do_op(16'hFFFF, 16'h0001, 1'b0, 1'b1, "R4 add carry");  sweep_conds();
    do_op(16'h8000, 16'h8000, 1'b0, 1'b1, "R3 add zero");   sweep_conds();
    do_op(16'hFFFE, 16'hFFFF, 1'b0, 1'b1, "R1 neg sum");    sweep_conds();
  endtask

  task automatic t_sub();
    do_op(16'h0005, 16'h0005, 1'b1, 1'b1, "R2 equal");      sweep_conds();
    do_op(16'h0003, 16'h0005, 1'b1, 1'b1, "R4 borrow");     sweep_conds();
    do_op(16'h8000, 16'h0001, 1'b1, 1'b1, "R5 sub ovf");    sweep_conds();
    do_op(16'h7FFF, 16'hFFFF, 1'b1, 1'b1, "R5 sub ovf2");   sweep_conds();
    do_op(16'hFFFF, 16'h0001, 1'b1, 1'b1, "R2 no borrow");  sweep_conds();
    do_op(16'h0000, 16'h0000, 1'b1, 1'b1, "R4 zero sub");   sweep_conds();
  endtask

  task automatic t_no_set();
    do_op(16'h0003, 16'h0005, 1'b1, 1'b1, "R6 setup");
    do_op(16'h0005, 16'h0005, 1'b1, 1'b0, "R6 hold");
    sweep_conds();
  endtask

  task automatic t_backpressure();
    logic [W-1:0] held;
    @(negedge clk);
    op_a = 16'h1234; op_b = 16'h0111; op_sub = 1'b0; set_flags = 1'b1;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    exp_f = model_flags(16'h1234, 16'h0111, 1'b0);
    held = model_res(16'h1234, 16'h0111, 1'b0);
    check("R11 first result", out_result, held);
    op_a = 16'h8000; op_b = 16'h8000; op_sub = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R11 ready low", in_ready, 0);
      @(negedge clk);
      check("R11 valid held", out_valid, 1);
      check("R11 result held", out_result, held);
      check_flags("R6 flags held under stall");
    end
    out_ready = 1'b1;
    #1;
    check("R11 ready back", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    exp_f = model_flags(16'h8000, 16'h8000, 1'b1);
    check("R11 next result", out_result, model_res(16'h8000, 16'h8000, 1'b1));
    check_flags("R3 flags after stall");
    @(negedge clk);
    check("R11 drained", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_no_set();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule